// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block moves a stream of fixed-width words from a producer running on one clock to a consumer running on a second, unrelated clock. The words themselves never pass through flop synchronizers. They are written into a register array from the write side and read back out of it on the read side. Only the two position counters travel between the domains.

Each side keeps its position as a binary counter that is one bit wider than the array address. It sends a Gray-coded copy of that counter to the other side through a chain of destination-clocked flops. The chain has either two or three stages, set by a parameter. The receiving side decodes the Gray value back to binary and compares it with its own counter. The write side does this to decide when the array is full, and the read side does it to decide when the array is empty.

Both flags come straight from registers. Read data is also registered, and it appears one read-clock edge after a read is accepted.

Top module: `dual_clock_fifo`

## Requirements
- R1: After both resets, `rempty` is 1, `wfull` is 0 and `rdata` is all zeros.
- R2: Every accepted word leaves the read side exactly once, in the order it was accepted, including across many wraps of the pointers.
- R3: `rdata` takes a new value only on a read-clock edge where `rtake` is 1 and `rempty` is 0. That value is the oldest unread word. On every other edge `rdata` holds its value.
- R4: With no reads, `wfull` stays 0 while DEPTH-1 or fewer words are unread. It reads 1 right after the write-clock edge that accepts the DEPTH-th unread word.
- R5: A write presented while `wfull` is 1 is dropped. The stored words and the write position are unchanged, so the dropped word never appears on the read side.
- R6: `rempty` reads 1 right after the read-clock edge that takes the last unread word.
- R7: A read presented while `rempty` is 1 is dropped. `rdata` is unchanged and the read position does not move, so the next word written is the next word read.
- R8: With STAGES flops in each chain, a word written into an empty FIFO clears `rempty` on exactly the (STAGES+1)-th read-clock edge after the write edge. A read from a full FIFO clears `wfull` on exactly the (STAGES+1)-th write-clock edge after the read edge.
- R9: The Gray pointer sent across each boundary changes in exactly one bit on each accepted operation, and it does not change otherwise. As a result, a sample taken mid-change decodes to either the old position or the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side reset, asynchronous, active low |
| wdata | input | W | Word to store |
| wput | input | 1 | Write request, accepted when `wfull` is 0 |
| wfull | output | 1 | FIFO holds DEPTH unread words |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side reset, asynchronous, active low |
| rdata | output | W | Registered word from the last accepted read |
| rtake | input | 1 | Read request, accepted when `rempty` is 0 |
| rempty | output | 1 | FIFO holds no unread words |

## Verification
Several patterns are used, and each one separates a different kind of fault:

- A short burst followed by a drain shows whether words keep their order and whether `rdata` holds while idle.
- Filling to exactly DEPTH-1 words and then to DEPTH words locates the full boundary. A write attempted while full, followed by a complete drain, shows whether that dropped word ever leaked into storage.
- Single writes into an empty FIFO, and single reads from a full one, are timed edge by edge to measure the crossing latency. A read issued while empty, followed by a fresh write, shows whether the read position moved.
- A long run in which both sides use irregular, independent request patterns forces many pointer wraps. It exposes any ordering or loss fault that only appears with concurrent traffic.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  // Wide carrier for pointer arithmetic; callers zero-extend and truncate.
  typedef logic [31:0] ptr_word_t;

  // Binary to reflected Gray: bit i = b[i] ^ b[i+1]
  function automatic ptr_word_t bin2gray(input ptr_word_t b);
    return b ^ (b >> 1);
  endfunction

  // Gray to binary: bit i = XOR of all Gray bits from the top down to i
  function automatic ptr_word_t gray2bin(input ptr_word_t g);
    ptr_word_t b;
    for (int i = 0; i < 32; i++) b[i] = ^(g >> i);
    return b;
  endfunction
endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
  parameter int          W         = 4,
  parameter int          STAGES    = 2,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  // First stage samples the foreign value directly.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RESET_VAL;
    else        chain[0] <= d;
  end

  // Remaining stages: flop to flop, nothing in between.
  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RESET_VAL;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/afifo_wside.sv
module afifo_wside
  import afifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wput,
  input  logic [PW-1:0] rgray_sync,
  output logic          wfull,
  output logic          wen,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray
);
  logic [PW-1:0] wbin, wbin_nx, rsync_bin;

  assign wen       = wput & ~wfull;
  assign wbin_nx   = wbin + PW'(wen);
  assign rsync_bin = PW'(gray2bin(ptr_word_t'(rgray_sync)));
  assign waddr     = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
      wfull <= 1'b0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= PW'(bin2gray(ptr_word_t'(wbin_nx)));
      wfull <= (wbin_nx - rsync_bin) == PW'(DEPTH);
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wput && wfull) |=> $stable(wbin));
  // R4
  fill_bound_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wbin - rsync_bin) <= PW'(DEPTH));
  // R9
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    wen |=> $countones(wgray ^ $past(wgray)) == 1);
  // R9
  wgray_idle_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    !wen |=> $stable(wgray));
endmodule

// File: rtl/afifo_rside.sv
module afifo_rside
  import afifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rtake,
  input  logic [PW-1:0] wgray_sync,
  output logic          rempty,
  output logic          ren,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray
);
  logic [PW-1:0] rbin, rbin_nx, wsync_bin;

  assign ren       = rtake & ~rempty;
  assign rbin_nx   = rbin + PW'(ren);
  assign wsync_bin = PW'(gray2bin(ptr_word_t'(wgray_sync)));
  assign raddr     = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      rempty <= 1'b1;
    end else begin
      rbin   <= rbin_nx;
      rgray  <= PW'(bin2gray(ptr_word_t'(rbin_nx)));
      rempty <= rbin_nx == wsync_bin;
    end
  end

  // R7
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rtake && rempty) |=> $stable(rbin));
  // R2
  drain_bound_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (wsync_bin - rbin) <= PW'(DEPTH));
  // R9
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    ren |=> $countones(rgray ^ $past(rgray)) == 1);
  // R9
  rgray_idle_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    !ren |=> $stable(rgray));
endmodule

// File: rtl/afifo_store.sv
module afifo_store #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          wen,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          ren,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (wen) cells[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)  rdata <= '0;
    else if (ren) rdata <= cells[raddr];
  end

  // R3
  rdata_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    !ren |=> $stable(rdata));
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int W      = 8,
  parameter int DEPTH  = 8,
  parameter int STAGES = 2
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic [W-1:0] wdata,
  input  logic         wput,
  output logic         wfull,
  input  logic         rclk,
  input  logic         rrst_n,
  output logic [W-1:0] rdata,
  input  logic         rtake,
  output logic         rempty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  // Named internal events for the checkers.
  logic          wen, ren;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_sync, rgray_sync;

  initial begin
    // DEPTH must be a power of two; chain length 2 or 3
    depth_pow2_chk: assert ((1 << AW) == DEPTH);
    stages_chk: assert (STAGES == 2 || STAGES == 3);
  end

  afifo_wside #(.DEPTH(DEPTH)) u_wside (
    .wclk(wclk), .wrst_n(wrst_n), .wput(wput), .rgray_sync(rgray_sync),
    .wfull(wfull), .wen(wen), .waddr(waddr), .wgray(wgray)
  );

  afifo_rside #(.DEPTH(DEPTH)) u_rside (
    .rclk(rclk), .rrst_n(rrst_n), .rtake(rtake), .wgray_sync(wgray_sync),
    .rempty(rempty), .ren(ren), .raddr(raddr), .rgray(rgray)
  );

  afifo_sync #(.W(PW), .STAGES(STAGES), .RESET_VAL('0)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_sync)
  );

  afifo_sync #(.W(PW), .STAGES(STAGES), .RESET_VAL('0)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_sync)
  );

  afifo_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .wclk(wclk), .wen(wen), .waddr(waddr), .wdata(wdata),
    .rclk(rclk), .rrst_n(rrst_n), .ren(ren), .raddr(raddr), .rdata(rdata)
  );
endmodule

// File: tb/dual_clock_fifo_test.sv
module dual_clock_fifo_test;
  localparam int W = 8;
  localparam int DEPTH = 8;
  localparam int STAGES = 2;
  localparam int WCLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 14;

  logic wclk, wrst_n, wput, wfull;
  logic rclk, rrst_n, rtake, rempty;
  logic [W-1:0] wdata, rdata;

  int errors = 0;
  int checks = 0;
  int model_q[$];

  dual_clock_fifo #(.W(W), .DEPTH(DEPTH), .STAGES(STAGES)) uut (
    .wclk(wclk), .wrst_n(wrst_n), .wdata(wdata), .wput(wput), .wfull(wfull),
    .rclk(rclk), .rrst_n(rrst_n), .rdata(rdata), .rtake(rtake), .rempty(rempty)
  );

  // Write posedges fall on odd times, read posedges on even: never together.
  initial begin
    wclk = 0;
    forever #(WCLK_PERIOD / 2) wclk = ~wclk;
  end
  initial begin
    rclk = 0;
    #4;
    forever begin
      rclk = 1; #(RCLK_PERIOD / 2);
      rclk = 0; #(RCLK_PERIOD / 2);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(WCLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
    $finish;
  end

  task automatic put_word(input logic [W-1:0] d);
    @(negedge wclk); wput = 1; wdata = d;
    @(negedge wclk); wput = 0;
  endtask

  task automatic take_word(output logic [W-1:0] d);
    @(negedge rclk); rtake = 1;
    @(negedge rclk); rtake = 0; d = rdata;
  endtask

  task automatic settle;
    repeat (8) @(negedge rclk);
    repeat (8) @(negedge wclk);
  endtask

  task automatic t_reset;
    @(negedge wclk);
    chk("R1 wfull after reset", int'(wfull), 0);
    chk("R1 rempty after reset", int'(rempty), 1);
    chk("R1 rdata after reset", int'(rdata), 0);
  endtask

  task automatic t_burst;
    logic [W-1:0] d;
    put_word(8'h11); put_word(8'h22); put_word(8'h33);
    settle();
    take_word(d); chk("R2 burst word0", int'(d), 'h11);
    take_word(d); chk("R2 burst word1", int'(d), 'h22);
    take_word(d); chk("R2 burst word2", int'(d), 'h33);
    chk("R6 empty after last take", int'(rempty), 1);
    repeat (5) @(negedge rclk);
    chk("R3 rdata held while idle", int'(rdata), 'h33);
  endtask

  task automatic t_empty_latency;
    int n;
    logic [W-1:0] d;
    @(negedge wclk); wput = 1; wdata = 8'h44;
    @(posedge wclk);
    fork begin @(negedge wclk); wput = 0; end join_none
    n = 0;
    while (rempty && n < 20) begin @(posedge rclk); #1; n++; end
    chk("R8 rempty release edges", n, STAGES + 1);
    take_word(d);
    chk("R2 latency word", int'(d), 'h44);
  endtask

  task automatic t_full;
    int n;
    logic [W-1:0] d;
    for (int i = 0; i < DEPTH - 1; i++) put_word(W'(8'hA0 + i));
    chk("R4 not full at DEPTH-1", int'(wfull), 0);
    put_word(W'(8'hA0 + DEPTH - 1));
    chk("R4 full at DEPTH", int'(wfull), 1);
    put_word(8'hEE);
    chk("R5 still full after dropped write", int'(wfull), 1);
    settle();
    @(negedge rclk); rtake = 1;
    @(posedge rclk);
    fork begin @(negedge rclk); rtake = 0; end join_none
    n = 0;
    while (wfull && n < 20) begin @(posedge wclk); #1; n++; end
    chk("R8 wfull release edges", n, STAGES + 1);
    @(negedge rclk);
    chk("R2 first word from full", int'(rdata), 'hA0);
    put_word(8'hB7);
    settle();
    for (int i = 1; i < DEPTH; i++) begin
      take_word(d);
      chk("R5 drain after dropped write", int'(d), 8'hA0 + i);
    end
    take_word(d);
    chk("R2 refill word after wrap", int'(d), 'hB7);
    chk("R6 empty after full drain", int'(rempty), 1);
  endtask

  task automatic t_read_empty;
    logic [W-1:0] d;
    take_word(d);
    chk("R7 rdata unchanged on empty read", int'(d), 'hB7);
    chk("R7 still empty", int'(rempty), 1);
    put_word(8'h5A);
    settle();
    take_word(d);
    chk("R7 read position did not move", int'(d), 'h5A);
  endtask

  task automatic t_stream;
    int received;
    received = 0;
    fork
      begin : writer
        logic [15:0] lf;
        int sent;
        lf = 16'hACE1; sent = 0;
        while (sent < 300) begin
          @(negedge wclk);
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          if (lf[0] && !wfull) begin
            wput = 1; wdata = W'(sent * 7 + 3);
            model_q.push_back(sent * 7 + 3);
            sent++;
          end else wput = 0;
        end
        @(negedge wclk); wput = 0;
      end
      begin : reader
        logic [15:0] lr;
        logic pend;
        int e;
        lr = 16'h1D0F; pend = 0;
        while (received < 300) begin
          @(negedge rclk);
          if (pend) begin
            e = model_q.pop_front();
            chk("R2 R9 stream order", int'(rdata), e & 'hFF);
            received++;
          end
          lr = {lr[14:0], lr[15] ^ lr[13] ^ lr[12] ^ lr[10]};
          pend = (lr[1] | lr[3]) && !rempty && received + 1 < 300 + 1;
          rtake = pend && (received < 300);
          pend = rtake;
        end
        rtake = 0;
      end
    join
    chk("R2 stream count", received, 300);
    settle();
    chk("R6 empty after stream", int'(rempty), 1);
  endtask

  initial begin
    wrst_n = 0; rrst_n = 0; wput = 0; rtake = 0; wdata = '0;
    #50;
    wrst_n = 1; rrst_n = 1;
    t_reset();
    t_burst();
    t_empty_latency();
    t_full();
    t_read_empty();
    t_stream();
    summary();
    $finish;
  end
endmodule